// File: doc/BRIEF.md
# Serial Display Link Transmitter

This block takes one 21-bit word of pixel and timing data per cycle of a pixel clock and sends it out on three serial data lanes. Each lane carries seven bits per pixel-clock period, so the lanes run at seven times the pixel rate. A fourth lane sends a fixed clock pattern in step with the data frames, so a receiver can recover frame alignment. Everything runs in the bit-clock domain, which is seven times the pixel clock. The pixel clock is oversampled there as a plain signal. A select input chooses whether words are taken on its rising or its falling edge.

Two conditions force every lane low. The first is a pixel clock that has stopped toggling for a set number of bit-clock cycles. The second is the active-low power-down input. After either condition clears, the block sends zeros until it has captured a complete new word. Then it starts on a frame boundary. Reset and power-down may be released in any order relative to the arrival of clock and data.

Top module: `disp_link_tx`

## Requirements
- R1: Lane L (L = 0..2) sends bits [7L+6:7L] of a captured word, most-significant bit first, over seven consecutive bit-clock cycles. Bit 7L is the last bit of the frame.
- R2: With `edge_rise_sel` = 1 a word is taken on each rising edge of `pix_clk`. With 0 it is taken on each falling edge. The word taken is the value of `pix_data` sampled on the same bit-clock edge that first samples the new `pix_clk` level.
- R3: While data is being sent, `clk_lane` repeats the 7-bit pattern 1100011, first bit leftmost, aligned to the data frames.
- R4: If 32 consecutive bit-clock cycles pass without any `pix_clk` transition reaching the edge detector, the clock is declared missing. All four lanes are then low from the next cycle on.
- R5: When `pix_clk` transitions return after a loss, the loss flag clears. Output resumes at the first frame boundary that follows a newly captured word.
- R6: While `pwr_dn_n` is low all lanes are low and all internal state is cleared. This holds whether `pwr_dn_n` is released before or after `pix_clk` starts.
- R7: After reset or power-down release, frame boundaries are at enabled bit-clock cycles 6, 13, 20, and so on. Cycle 0 is the first cycle enabled. All lanes stay low until a boundary with a captured word available. A word whose edge is sampled at enabled cycle k (k >= 1) is ready for the first boundary at or after cycle k+3.
- R8: The word on the lanes changes only at a frame boundary, even when `pix_data` changes on every bit clock. A boundary takes the most recent word captured since the previous boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, oversampled as data |
| pix_data | input | 21 | Parallel pixel and timing word |
| pwr_dn_n | input | 1 | Active-low power-down |
| edge_rise_sel | input | 1 | 1: capture on rising edge, 0: on falling edge |
| data_lane | output | 3 | Serial data lanes, bit L is lane L |
| clk_lane | output | 1 | Forwarded clock-pattern lane |

## Verification
The bench uses both capture edges, with data that changes only at the opposite edge and also with data that changes on every bit clock. A design that took the wrong edge, or sampled data one bit clock off, would send a neighbouring word. A design that reloaded mid-frame would send torn frames. The pixel clock is stopped long enough to trip loss detection and is then restarted. A design whose idle count was off by one, or that kept sending stale words after recovery, would mismatch the model. Power-down is released both before and after the pixel clock starts. A design that needed a fixed start-up order would send garbage, or nothing, where the model expects a clean start.

// File: rtl/disp_link_pkg.sv
package disp_link_pkg;

    parameter int unsigned LANES      = 3;
    parameter int unsigned BITS       = 7;
    parameter int unsigned LOSS_LIMIT = 32;

    localparam int unsigned WORD_W = LANES * BITS;
    localparam int unsigned FCNT_W = $clog2(BITS);
    localparam int unsigned IDLE_W = $clog2(LOSS_LIMIT + 1);

    typedef logic [BITS-1:0]   frame_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [FCNT_W-1:0] fcnt_t;
    typedef logic [IDLE_W-1:0] idle_t;

    parameter frame_t CLK_PATTERN = 7'b1100011;

    typedef struct packed {
        logic any;   // any pixel-clock transition seen
        logic sel;   // transition matches the selected polarity
    } edge_ev_t;

    function automatic frame_t lane_slice(word_t w, int unsigned lane);
        return w[lane*BITS +: BITS];
    endfunction

endpackage

// File: rtl/disp_link_edge_sync.sv
module disp_link_edge_sync
    import disp_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     pix_clk,
    input  word_t    pix_data,
    input  logic     rise_sel,
    output edge_ev_t ev,
    output word_t    cap_data
);

    logic    s1, s2, s3;
    word_t   d1, d2;
    logic [1:0] warm;
    logic    warm_ok;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s3   <= 1'b0;
            d1   <= '0;
            d2   <= '0;
            warm <= '0;
        end else begin
            s1 <= pix_clk;
            s2 <= s1;
            s3 <= s2;
            d1 <= pix_data;
            d2 <= d1;
            if (warm != 2'd3)
                warm <= warm + 2'd1;
        end
    end

    // history is real only once s3 holds a sample taken after enable
    assign warm_ok  = (warm == 2'd3);
    assign ev.any   = warm_ok && (s2 != s3);
    assign ev.sel   = ev.any && (s2 == rise_sel);
    assign cap_data = d2;

endmodule

// File: rtl/disp_link_clk_mon.sv
module disp_link_clk_mon
    import disp_link_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  edge_ev_t ev,
    output logic     lost_nxt,
    output logic     lost
);

    idle_t idle, idle_nxt;

    always_comb begin
        if (ev.any)
            idle_nxt = '0;
        else if (idle == IDLE_W'(LOSS_LIMIT))
            idle_nxt = idle;
        else
            idle_nxt = idle + IDLE_W'(1);
        lost_nxt = (idle_nxt == IDLE_W'(LOSS_LIMIT));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idle <= '0;
            lost <= 1'b0;
        end else begin
            idle <= idle_nxt;
            lost <= lost_nxt;
        end
    end

    assert_loss_declared_R4: assert property (@(posedge clk) disable iff (rst || !en)
        (idle == IDLE_W'(LOSS_LIMIT - 1) && !ev.any) |=> lost);

    assert_loss_clears_R5: assert property (@(posedge clk) disable iff (rst || !en)
        (lost && ev.any) |=> !lost);

endmodule

// File: rtl/disp_link_serializer.sv
module disp_link_serializer
    import disp_link_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  edge_ev_t         ev,
    input  word_t            cap_data,
    input  logic             lost_nxt,
    input  logic             lost,
    output logic [LANES-1:0] lane_out,
    output logic             clk_out
);

    fcnt_t  fcnt;
    word_t  hold;
    logic   hold_vld;
    logic   active;
    logic   load;
    frame_t ck_sh;

    assign load = (fcnt == FCNT_W'(BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            fcnt     <= '0;
            hold     <= '0;
            hold_vld <= 1'b0;
            active   <= 1'b0;
            ck_sh    <= '0;
        end else begin
            fcnt  <= load ? '0 : fcnt + FCNT_W'(1);
            ck_sh <= load ? CLK_PATTERN : {ck_sh[BITS-2:0], 1'b0};
            if (lost_nxt) begin
                hold_vld <= 1'b0;
                active   <= 1'b0;
            end else begin
                if (load)
                    active <= hold_vld;
                if (ev.sel) begin
                    hold     <= cap_data;
                    hold_vld <= 1'b1;
                end else if (load) begin
                    hold_vld <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        frame_t sh;
        always_ff @(posedge clk) begin
            if (rst || !en)
                sh <= '0;
            else if (load)
                sh <= lane_slice(hold, g);
            else
                sh <= {sh[BITS-2:0], 1'b0};
        end
        assign lane_out[g] = sh[BITS-1] & active;
    end

    assign clk_out = ck_sh[BITS-1] & active;

    assert_clk_pattern_R3: assert property (@(posedge clk) disable iff (rst || !en)
        active |-> (clk_out == CLK_PATTERN[FCNT_W'(BITS - 1) - fcnt]));

    assert_frame_intact_R8: assert property (@(posedge clk) disable iff (rst || !en)
        (fcnt != '0 && !lost) |-> $stable(active));

endmodule

// File: rtl/disp_link_tx.sv
module disp_link_tx
    import disp_link_pkg::*;
(
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic [WORD_W-1:0] pix_data,
    input  logic              pwr_dn_n,
    input  logic              edge_rise_sel,
    output logic [LANES-1:0]  data_lane,
    output logic              clk_lane
);

    edge_ev_t ev;
    word_t    cap_data;
    logic     lost_nxt;
    logic     lost;

    disp_link_edge_sync u_sync (
        .clk      (clk_bit),
        .rst      (rst),
        .en       (pwr_dn_n),
        .pix_clk  (pix_clk),
        .pix_data (pix_data),
        .rise_sel (edge_rise_sel),
        .ev       (ev),
        .cap_data (cap_data)
    );

    disp_link_clk_mon u_mon (
        .clk      (clk_bit),
        .rst      (rst),
        .en       (pwr_dn_n),
        .ev       (ev),
        .lost_nxt (lost_nxt),
        .lost     (lost)
    );

    disp_link_serializer u_ser (
        .clk      (clk_bit),
        .rst      (rst),
        .en       (pwr_dn_n),
        .ev       (ev),
        .cap_data (cap_data),
        .lost_nxt (lost_nxt),
        .lost     (lost),
        .lane_out (data_lane),
        .clk_out  (clk_lane)
    );

    assert_lanes_low_lost_R4: assert property (@(posedge clk_bit) disable iff (rst || !pwr_dn_n)
        lost |-> (data_lane == '0 && clk_lane == 1'b0));

    assert_powerdown_quiet_R6: assert property (@(posedge clk_bit) disable iff (rst)
        !pwr_dn_n |=> (data_lane == '0 && clk_lane == 1'b0));

endmodule

// File: tb/disp_link_tx_tb.sv
module disp_link_tx_tb;

    localparam int LN = 3;
    localparam int FB = 7;
    localparam int WW = LN * FB;
    localparam int LIM = 32;
    localparam logic [6:0] PAT = 7'b1100011;

    logic          clk_bit = 1'b0;
    logic          rst = 1'b1;
    logic          pix_clk = 1'b0;
    logic [WW-1:0] pix_data = '0;
    logic          pwr_dn_n = 1'b1;
    logic          edge_rise_sel = 1'b1;
    logic [LN-1:0] data_lane;
    logic          clk_lane;

    int total = 0;
    int bad = 0;
    string phase_tag = "R1";
    bit pclk_run = 1'b1;
    int data_mode = 0;          // 0 change at opposite edge, 1 every cycle, 2 fixed
    logic [WW-1:0] fix_word = '0;
    int ph = 0;

    always #4 clk_bit = ~clk_bit;

    disp_link_tx u_dut (
        .clk_bit      (clk_bit),
        .rst          (rst),
        .pix_clk      (pix_clk),
        .pix_data     (pix_data),
        .pwr_dn_n     (pwr_dn_n),
        .edge_rise_sel(edge_rise_sel),
        .data_lane    (data_lane),
        .clk_lane     (clk_lane)
    );

    // stimulus source: pixel clock is bit clock / 7, driven away from the active edge
    always @(negedge clk_bit) begin
        logic nv;
        nv = pix_clk;
        if (pclk_run) begin
            ph = (ph == 6) ? 0 : ph + 1;
            nv = (ph < 4);
        end
        if (data_mode == 2)
            pix_data <= fix_word;
        else if (data_mode == 1)
            pix_data <= WW'($urandom);
        else if (nv != pix_clk && nv != edge_rise_sel)
            pix_data <= WW'($urandom);
        pix_clk <= nv;
    end

    // behavioural reference model
    int j = 0;
    int idle = 0;
    bit m_lost = 1'b0;
    bit m_act = 1'b0;
    int pos = 0;
    logic [WW-1:0] m_word = '0;
    logic [WW-1:0] capq[$];
    logic hp[4];
    logic [WW-1:0] hd[4];
    logic [LN-1:0] exp_d = '0;
    logic exp_c = 1'b0;
    bit started = 1'b0;

    always @(posedge clk_bit) begin
        started = 1'b1;
        if (rst || !pwr_dn_n) begin
            j = 0; idle = 0; m_lost = 0; m_act = 0; pos = 0;
            capq.delete();
        end else begin
            bit anyv, selv;
            for (int i = 3; i > 0; i--) begin hp[i] = hp[i-1]; hd[i] = hd[i-1]; end
            hp[0] = pix_clk; hd[0] = pix_data;
            anyv = (j >= 3) && (hp[2] != hp[3]);
            selv = anyv && (hp[2] == edge_rise_sel);
            if (anyv) idle = 0;
            else if (idle < LIM) idle++;
            m_lost = (idle == LIM);
            if (m_lost) begin
                capq.delete();
                m_act = 0;
            end else if (j % FB == FB - 1) begin
                if (capq.size() > 0) begin
                    m_word = capq[$];
                    m_act = 1;
                end else begin
                    m_act = 0;
                end
                capq.delete();
            end
            if (j % FB == FB - 1) pos = 0; else pos++;
            if (!m_lost && selv) capq.push_back(hd[2]);
            j++;
        end
        exp_c = 1'b0;
        exp_d = '0;
        if (m_act && !rst && pwr_dn_n) begin
            exp_c = PAT[6-pos];
            for (int l = 0; l < LN; l++) exp_d[l] = m_word[l*FB + FB - 1 - pos];
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk_bit) begin
        if (started) begin
            string dtag, ctag;
            if (rst || !pwr_dn_n) begin dtag = "R6"; ctag = "R6"; end
            else if (m_lost) begin dtag = "R4"; ctag = "R4"; end
            else if (!m_act) begin dtag = "R7"; ctag = "R7"; end
            else begin dtag = phase_tag; ctag = "R3"; end
            total++;
            if (data_lane !== exp_d) begin
                bad++;
                $display("FAIL %s data lanes t=%0t actual=%b expected=%b", dtag, $time, data_lane, exp_d);
            end
            total++;
            if (clk_lane !== exp_c) begin
                bad++;
                $display("FAIL %s clock lane t=%0t actual=%b expected=%b", ctag, $time, clk_lane, exp_c);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk_bit);
    endtask

    bit done = 1'b0;

    initial begin
        run(5);
        // R7: reset state, lanes low
        total++;
        if (data_lane !== '0 || clk_lane !== 1'b0) begin
            bad++;
            $display("FAIL R7 reset lanes actual=%b%b expected=0000", data_lane, clk_lane);
        end
        rst = 1'b0;
        phase_tag = "R1";
        run(150);
        // R2: falling-edge capture after power-down
        pwr_dn_n = 1'b0; run(5);
        edge_rise_sel = 1'b0; phase_tag = "R2";
        pwr_dn_n = 1'b1; run(150);
        // R8: data churns every bit clock
        data_mode = 1; phase_tag = "R8"; run(100);
        // R1: fixed patterns, back on the rising edge
        edge_rise_sel = 1'b1; data_mode = 2; phase_tag = "R1";
        fix_word = 21'h155555; run(30);
        fix_word = 21'h1FFFFF; run(30);
        fix_word = 21'h000001; run(30);
        fix_word = 21'h100000; run(30);
        data_mode = 0;
        // R4 then R5: clock stops, then returns
        phase_tag = "R4"; pclk_run = 1'b0; run(60);
        phase_tag = "R5"; pclk_run = 1'b1; run(80);
        // R6: release power-down before the clock starts
        pclk_run = 1'b0; pwr_dn_n = 1'b0; run(10);
        phase_tag = "R6"; pwr_dn_n = 1'b1; run(20);
        phase_tag = "R5"; pclk_run = 1'b1; run(80);
        // R6: power-down with clock running, released after
        pwr_dn_n = 1'b0; run(12);
        phase_tag = "R6"; pwr_dn_n = 1'b1; run(80);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_bit);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule